// File: doc/BRIEF.md
# Tiered Bus Ownership Arbiter

This block decides which master may drive a shared backplane bus next. Six sources can ask for the bus. Two of them are on-chip: an interrupt-acknowledge engine and a programmed-I/O master. The other four are backplane request levels, numbered 0 to 3. The arbiter issues a grant only while the bus is free. It holds that grant until the chosen master signals that it has taken the bus. It then stays out of the way until the bus is released. For a backplane level, the grant bit feeds that level's daisy-chained grant-out line.

The sources fall into four tiers, from strongest to weakest: the interrupt engine, then the programmed-I/O master, then backplane level 3, then a ring made of levels 2, 1 and 0. Inside the ring a rotating pointer keeps the choice fair. The level granted most recently drops to the bottom, and the level just below it in the descending sequence 2, 1, 0, 2, … moves to the top. A bus-clear hint tells the present owner that a stronger tier is waiting.

The controller has three states. IDLE waits for a free bus and a request. GRANT drives the chosen grant line. OWNED waits for the owner to finish. The transitions are: IDLE→GRANT when the bus is free and any request is present; GRANT→OWNED when bus busy rises; GRANT→IDLE when the granted master drops its request before taking the bus; OWNED→IDLE when bus busy falls.

Top module: `bus_owner_arb`

## Requirements
- R1: While reset is held and in the first cycle after it, all grant outputs and `bus_clr` are low. The ring pointer starts so that level 2 is the first ring level served.
- R2: A grant is issued from IDLE only in a cycle where `bus_busy` is sampled low. It appears on the outputs one clock after that sample. At most one grant bit is ever high. While `bus_busy` is high in IDLE, no grant is issued.
- R3: The interrupt engine (`req_ih`) wins over every other source. The programmed-I/O master (`req_pio`) wins over all four backplane levels.
- R4: Backplane level 3 (`req_bp[3]`) wins over levels 2, 1 and 0.
- R5: Among levels 2, 1 and 0, after a grant to level L the search order is L-1, L-2, …, wrapping from 0 to 2, with L itself last.
- R6: The ring pointer moves only when a grant goes to level 2, 1 or 0. Grants to the interrupt engine, the programmed-I/O master or level 3 leave it unchanged.
- R7: A grant stays high until `bus_busy` is sampled high. It drops on the next edge. No grant is driven while the owner holds the bus.
- R8: If the granted master drops its request before `bus_busy` rises, the grant is withdrawn on the next edge and the arbiter returns to IDLE.
- R9: In OWNED, `bus_clr` is high exactly when a request from a strictly stronger tier than the owner's is present. The ring levels count as one tier.
- R10: After `bus_busy` falls, the arbiter spends one cycle in IDLE. The next grant appears on the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ih | input | 1 | Request from the interrupt-acknowledge engine |
| req_pio | input | 1 | Request from the programmed-I/O master |
| req_bp | input | RING_LEVELS+1 | Backplane request levels; bit i is level i |
| bus_busy | input | 1 | High while some master holds the bus |
| gnt_ih | output | 1 | Grant to the interrupt engine |
| gnt_pio | output | 1 | Grant to the programmed-I/O master |
| gnt_bp | output | RING_LEVELS+1 | Per-level grant, drives that level's grant-out chain |
| bus_clr | output | 1 | Hint to the present owner that a stronger tier is waiting |

## Verification
The bench walks the ring through a full rotation, a lone request that moves the pointer, and a wrap from level 0 back to level 2. An arbiter with the rotation reversed, or with a fixed ring order, would serve the levels in the wrong sequence. It also interleaves grants to the fixed tiers between ring grants. A pointer that moved on those grants would start the next ring round at the wrong level. Other cases cover a request raised while a foreign owner holds the bus, a request withdrawn before the bus is taken, and the bus-clear hint for the same, weaker and stronger tiers. A design that ignored busy would grant early. One that missed the withdrawal would hang in GRANT. One that compared tiers loosely would raise the clear hint for a peer in the ring or for a weaker master.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_OWNED = 2'd2
    } arb_state_t;

    // Lower value means stronger tier
    typedef enum logic [1:0] {
        TIER_IH   = 2'd0,
        TIER_PIO  = 2'd1,
        TIER_TOP  = 2'd2,
        TIER_RING = 2'd3
    } arb_tier_t;

endpackage

// File: rtl/bus_arb_ring.sv
module bus_arb_ring #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] pick,
    output logic         any
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last_q;
    logic [IW-1:0] pick_idx;
    int            idx;

    // Search downward from the level below the last one served
    always_comb begin
        pick     = '0;
        pick_idx = '0;
        any      = 1'b0;
        idx      = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last_q) + N - k) % N;
            if (!any && req[idx]) begin
                any         = 1'b1;
                pick[idx]   = 1'b1;
                pick_idx    = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (adv && any) begin
            last_q <= pick_idx;
        end
    end

endmodule

// File: rtl/bus_arb_tier_sel.sv
module bus_arb_tier_sel
    import bus_arb_pkg::*;
#(
    parameter int N = 3
) (
    input  logic          req_ih,
    input  logic          req_pio,
    input  logic          req_top,
    input  logic [N-1:0]  ring_pick,
    input  logic          ring_any,
    output logic [N+2:0]  win,
    output arb_tier_t     tier,
    output logic          valid
);
    always_comb begin
        win   = '0;
        tier  = TIER_RING;
        valid = 1'b1;
        if (req_ih) begin
            win[N+2] = 1'b1;
            tier     = TIER_IH;
        end else if (req_pio) begin
            win[N+1] = 1'b1;
            tier     = TIER_PIO;
        end else if (req_top) begin
            win[N]   = 1'b1;
            tier     = TIER_TOP;
        end else if (ring_any) begin
            win[N-1:0] = ring_pick;
            tier       = TIER_RING;
        end else begin
            valid = 1'b0;
        end
    end

endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
    import bus_arb_pkg::*;
#(
    parameter int RING_LEVELS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_ih,
    input  logic                   req_pio,
    input  logic [RING_LEVELS:0]   req_bp,
    input  logic                   bus_busy,
    output logic                   gnt_ih,
    output logic                   gnt_pio,
    output logic [RING_LEVELS:0]   gnt_bp,
    output logic                   bus_clr
);
    localparam int BP   = RING_LEVELS + 1;
    localparam int NSRC = RING_LEVELS + 3;

    arb_state_t       state_q, state_d;
    logic [NSRC-1:0]  win_q, win_c, req_all, gnt_vec;
    arb_tier_t        tier_q, tier_c;
    logic             win_valid, ring_any, load, higher;
    logic [RING_LEVELS-1:0] ring_pick;

    assign req_all = {req_ih, req_pio, req_bp};

    bus_arb_ring #(.N(RING_LEVELS)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_bp[RING_LEVELS-1:0]),
        .adv   (load && (tier_c == TIER_RING)),
        .pick  (ring_pick),
        .any   (ring_any)
    );

    bus_arb_tier_sel #(.N(RING_LEVELS)) u_sel (
        .req_ih    (req_ih),
        .req_pio   (req_pio),
        .req_top   (req_bp[RING_LEVELS]),
        .ring_pick (ring_pick),
        .ring_any  (ring_any),
        .win       (win_c),
        .tier      (tier_c),
        .valid     (win_valid)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!bus_busy && win_valid) state_d = ST_GRANT;
            ST_GRANT: begin
                if (bus_busy)                     state_d = ST_OWNED;
                else if (!(|(req_all & win_q)))   state_d = ST_IDLE;
            end
            ST_OWNED: if (!bus_busy)              state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    assign load = (state_q == ST_IDLE) && (state_d == ST_GRANT);

    // State register with captured winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            win_q   <= '0;
            tier_q  <= TIER_RING;
        end else begin
            state_q <= state_d;
            if (load) begin
                win_q  <= win_c;
                tier_q <= tier_c;
            end
        end
    end

    // Outputs
    always_comb begin
        gnt_vec = (state_q == ST_GRANT) ? win_q : '0;
        gnt_ih  = gnt_vec[NSRC-1];
        gnt_pio = gnt_vec[NSRC-2];
        gnt_bp  = gnt_vec[BP-1:0];
        higher  = (req_ih  && (tier_q != TIER_IH))
               || (req_pio && (tier_q >  TIER_PIO))
               || (req_bp[RING_LEVELS] && (tier_q == TIER_RING));
        bus_clr = (state_q == ST_OWNED) && higher;
    end

endmodule

// File: rtl/bus_owner_arb_chk.sv
module bus_owner_arb_chk #(
    parameter int RING_LEVELS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ih,
    input logic                 req_pio,
    input logic [RING_LEVELS:0] req_bp,
    input logic                 bus_busy,
    input logic                 gnt_ih,
    input logic                 gnt_pio,
    input logic [RING_LEVELS:0] gnt_bp,
    input logic                 bus_clr
);
    logic gnt_any, ring_gnt;
    assign gnt_any  = gnt_ih || gnt_pio || (|gnt_bp);
    assign ring_gnt = |gnt_bp[RING_LEVELS-1:0];

    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_ih, gnt_pio, gnt_bp}));

    a_r2_grant_on_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_any) |-> !$past(bus_busy));

    a_r7_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && bus_busy) |=> !gnt_any);

    a_r3_ih_over_pio: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_pio) |-> !$past(req_ih));

    a_r4_top_over_ring: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_gnt) |-> !$past(req_bp[RING_LEVELS] || req_ih || req_pio));

    a_r9_clr_needs_stronger: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clr |-> (req_ih || req_pio || req_bp[RING_LEVELS]));

    a_r9_clr_only_while_owned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clr |-> !gnt_any);

endmodule

bind bus_owner_arb bus_owner_arb_chk #(.RING_LEVELS(RING_LEVELS)) u_chk (.*);

// File: tb/sim_bus_owner_arb.sv
module sim_bus_owner_arb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] rq = '0;
    logic       bus_busy = 1'b0;
    logic       gnt_ih, gnt_pio, bus_clr;
    logic [3:0] gnt_bp;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    localparam logic [5:0] G_IH  = 6'b100000;
    localparam logic [5:0] G_PIO = 6'b010000;
    localparam logic [5:0] G_B3  = 6'b001000;
    localparam logic [5:0] G_B2  = 6'b000100;
    localparam logic [5:0] G_B1  = 6'b000010;
    localparam logic [5:0] G_B0  = 6'b000001;

    always #5 clk = ~clk;

    bus_owner_arb u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_ih   (rq[5]),
        .req_pio  (rq[4]),
        .req_bp   (rq[3:0]),
        .bus_busy (bus_busy),
        .gnt_ih   (gnt_ih),
        .gnt_pio  (gnt_pio),
        .gnt_bp   (gnt_bp),
        .bus_clr  (bus_clr)
    );

    function automatic logic [5:0] gnt_now();
        return {gnt_ih, gnt_pio, gnt_bp};
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk_g(string tag, logic [5:0] exp);
        n_chk++;
        if (gnt_now() !== exp) begin
            n_bad++;
            $display("FAIL %s: grant act=%b exp=%b", tag, gnt_now(), exp);
        end
    endtask

    task automatic chk_c(string tag, logic exp);
        n_chk++;
        if (bus_clr !== exp) begin
            n_bad++;
            $display("FAIL %s: bus_clr act=%b exp=%b", tag, bus_clr, exp);
        end
    endtask

    // Granted master takes the bus, uses it, releases it
    task automatic own(string tag, logic [5:0] exp);
        chk_g(tag, exp);
        bus_busy = 1'b1;
        rq = rq & ~exp;
        cyc();
        chk_g({tag, " R7 dropped on take"}, '0);
        bus_busy = 1'b0;
        cyc();
        chk_g({tag, " R10 idle cycle after release"}, '0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        chk_g("R1 during reset", '0);
        chk_c("R1 during reset", 1'b0);
        rst_n = 1'b1;
        cyc();
        chk_g("R1 after reset", '0);
        chk_c("R1 after reset", 1'b0);
    endtask

    task automatic t_tiers();
        rq = 6'b111111;
        cyc(); own("R3 ih first", G_IH);
        cyc(); own("R3 pio second", G_PIO);
        cyc(); own("R4 level3 over ring", G_B3);
        cyc(); own("R5 ring starts at 2", G_B2);
        cyc(); own("R5 then 1", G_B1);
        cyc(); own("R5 then 0", G_B0);
        rq = '0;
    endtask

    task automatic t_ring();
        rq = G_B2 | G_B1 | G_B0;
        cyc(); own("R5 lap 2", G_B2);
        cyc(); own("R5 lap 1", G_B1);
        cyc(); own("R5 lap 0", G_B0);
        rq = G_B1;
        cyc(); own("R5 lone 1", G_B1);
        rq = G_B2 | G_B1 | G_B0;
        cyc(); own("R5 after 1 comes 0", G_B0);
        cyc(); own("R5 wrap to 2", G_B2);
        cyc(); own("R5 then 1 last", G_B1);
        rq = '0;
    endtask

    task automatic t_pointer_hold();
        rq = G_B3;  cyc(); own("R6 level3", G_B3);
        rq = G_IH;  cyc(); own("R6 ih", G_IH);
        rq = G_PIO; cyc(); own("R6 pio", G_PIO);
        rq = G_B2 | G_B1 | G_B0;
        cyc(); own("R6 pointer unchanged", G_B0);
        cyc(); own("R6 next 2", G_B2);
        cyc(); own("R6 next 1", G_B1);
        rq = '0;
    endtask

    task automatic t_busy_block();
        bus_busy = 1'b1;
        rq = G_B3;
        cyc(); chk_g("R2 held by foreign owner", '0);
        cyc(); chk_g("R2 still held", '0);
        bus_busy = 1'b0;
        cyc(); own("R2 grant after free", G_B3);
        rq = '0;
    endtask

    task automatic t_clear();
        rq = G_B1;
        cyc(); chk_g("R9 setup ring owner", G_B1);
        bus_busy = 1'b1;
        rq = '0;
        cyc();
        chk_c("R9 nothing pending", 1'b0);
        rq = G_B0;
        #1 chk_c("R9 same tier peer", 1'b0);
        rq = G_B0 | G_PIO;
        #1 chk_c("R9 stronger pending", 1'b1);
        cyc();
        chk_c("R9 stays while owned", 1'b1);
        chk_g("R7 no grant while owned", '0);
        bus_busy = 1'b0;
        cyc();
        chk_c("R9 low after release", 1'b0);
        chk_g("R10 idle after release", '0);
        cyc(); own("R9 stronger served", G_PIO);
        cyc(); own("R9 ring peer served", G_B0);
        rq = G_IH;
        cyc(); chk_g("R9 setup ih owner", G_IH);
        bus_busy = 1'b1;
        rq = '0;
        cyc();
        rq = G_PIO;
        #1 chk_c("R9 weaker pending", 1'b0);
        bus_busy = 1'b0;
        cyc(); cyc();
        own("R9 pio after ih", G_PIO);
        rq = '0;
    endtask

    task automatic t_withdraw();
        rq = G_B3;
        cyc(); chk_g("R8 granted", G_B3);
        rq = '0;
        cyc(); chk_g("R8 withdrawn", '0);
        cyc(); chk_g("R8 stays idle", '0);
    endtask

    initial begin
        t_reset();
        t_tiers();
        t_ring();
        t_pointer_hold();
        t_busy_block();
        t_clear();
        t_withdraw();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule